// File: doc/BRIEF.md
# Segmented Comparand Port with Address Stepping

This block carries 64-bit comparand words across a 16-bit data bus, one 16-bit segment per data cycle. A write counter picks the segment that each write cycle loads. A separate read counter picks the segment that appears on the read bus. Each counter walks from a programmable start segment to a programmable end segment and then returns to the start. Because the two counters are separate, a read sequence never moves the write position, and a write sequence never moves the read position.

When the data cycles are aimed at memory and not at the comparand, the comparand is left alone. In that case, a data access to the end-limit segment steps the active memory address register. An instruction-level strobe steps it in the same way. A two-bit mode chooses the direction of the step, or holds the address still. There are two address registers, foreground and background. A select input chooses which one is active, and only the active one is loaded, stepped and driven out. The memory array and the instruction decode are outside this block.

The style centres on state machines, which does not suit this block. Its state is held in two segment counters and two address registers, not in named sequencer states. The step-mode decode is the block's only enumeration: HOLD, UP, DOWN and HOLD_ALT.

Top module: `segport_top`

## Requirements
- R1: After reset, both segment counters are 0. The comparand is all zeros, and both address registers are zero.
- R2: A write cycle (cyc_valid=1, cyc_write=1, mem_target=0) loads wr_data into comparand bits [16k+15:16k], where k is the write counter. The other bits do not change.
- R3: When mem_target=0, rd_data shows comparand segment k, where k is the read counter. When mem_target=1, rd_data is zero.
- R4: After an access in a given direction, that direction's counter reloads seg_start if it was at seg_end. Otherwise it advances by one, modulo 4.
- R5: Read cycles do not move the write counter, and write cycles do not move the read counter.
- R6: Data cycles with mem_target=1 leave the comparand unchanged.
- R7: A data cycle with mem_target=1 whose segment equals seg_end steps the active address register. step_mode 01 adds one, 10 subtracts one, and 00 or 11 holds. Stepping wraps modulo DEPTH.
- R8: A pulse on instr_step steps the active address register by the same rule as R7.
- R9: ar_load writes ar_load_val into the active address register. It takes priority over a step in the same cycle.
- R10: addr_out shows the active register, which is background when bg_sel=1. The inactive register never changes.
- R11: A memory-targeted data cycle at a segment other than seg_end does not step the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | Data-cycle strobe |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| mem_target | input | 1 | Data cycles address memory through the address register |
| wr_data | input | 16 | Write data segment |
| seg_start | input | 2 | First segment of the sequence |
| seg_end | input | 2 | Last segment of the sequence |
| step_mode | input | 2 | 00 hold, 01 up, 10 down, 11 hold |
| bg_sel | input | 1 | Select the background register set |
| ar_load | input | 1 | Load the active address register |
| ar_load_val | input | 4 | Value to load |
| instr_step | input | 1 | Instruction-level address step |
| rd_data | output | 16 | Read data segment |
| cmp_word | output | 64 | Comparand register |
| addr_out | output | 4 | Active address register |

## Verification
Assertions watch every cycle for several things. They check that a segment counter reloads its start after reaching the end limit, and that it does not move when idle. They check that a comparand write lands only in the selected segment, that an idle comparand stays stable, and that a load lands in the active address register. They also check that the inactive address register never changes, and that a held step mode keeps the address fixed. Only the bench scenarios can show the rest. These include the data order across long read/write sequences, the independence of the two counters, and stepping only on the end-limit segment. They also include wrap in both directions at the edges of the address range, and the priority of a load over a simultaneous step.

// File: rtl/segport_pkg.sv
package segport_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD     = 2'b00,
        STEP_UP       = 2'b01,
        STEP_DOWN     = 2'b10,
        STEP_HOLD_ALT = 2'b11
    } step_e;
endpackage

// File: rtl/segport_seg_ctr.sv
module segport_seg_ctr #(
    parameter int NSEG  = 4,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic [SEL_W-1:0] lim_start,
    input  logic [SEL_W-1:0] lim_end,
    output logic [SEL_W-1:0] pos,
    output logic             at_end
);
    logic [SEL_W-1:0] pos_nxt;

    assign at_end = (pos == lim_end);

    always_comb begin
        pos_nxt = pos;
        if (adv) begin
            if (at_end)
                pos_nxt = lim_start;
            else if (int'(pos) == NSEG - 1)
                pos_nxt = '0;
            else
                pos_nxt = pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos <= '0;
        else        pos <= pos_nxt;
    end

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adv && (pos == lim_end) |=> pos == $past(lim_start));

    assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(pos));
endmodule

// File: rtl/segport_cmp_reg.sv
module segport_cmp_reg #(
    parameter int DATA_W = 16,
    parameter int NSEG   = 4,
    parameter int SEL_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [SEL_W-1:0]       wr_sel,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [SEL_W-1:0]       rd_sel,
    output logic [DATA_W*NSEG-1:0] word,
    output logic [DATA_W-1:0]      rd_seg
);
    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (!rst_n)
                word[g*DATA_W +: DATA_W] <= '0;
            else if (wr_en && (int'(wr_sel) == g))
                word[g*DATA_W +: DATA_W] <= wdata;
        end
    end

    assign rd_seg = word[rd_sel*DATA_W +: DATA_W];

    assert_seg_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> word[$past(wr_sel)*DATA_W +: DATA_W] == $past(wdata));

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word));
endmodule

// File: rtl/segport_addr_unit.sv
module segport_addr_unit
    import segport_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic [1:0]    mode,
    input  logic          bg_sel,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [AW-1:0] ar_q [2];
    logic [AW-1:0] act;
    logic [AW-1:0] act_nxt;
    step_e         mode_e;

    assign mode_e = step_e'(mode);
    assign act    = ar_q[bg_sel];
    assign addr   = act;

    always_comb begin
        act_nxt = act;
        if (load) begin
            act_nxt = load_val;
        end else if (step) begin
            unique case (mode_e)
                STEP_UP:   act_nxt = (act == LAST) ? '0 : act + 1'b1;
                STEP_DOWN: act_nxt = (act == '0) ? LAST : act - 1'b1;
                STEP_HOLD, STEP_HOLD_ALT: act_nxt = act;
            endcase
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_set
        always_ff @(posedge clk) begin
            if (!rst_n)
                ar_q[g] <= '0;
            else if (int'(bg_sel) == g)
                ar_q[g] <= act_nxt;
        end
    end

    assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ar_q[$past(bg_sel)] == $past(load_val));

    assert_fg_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bg_sel |=> $stable(ar_q[0]));

    assert_bg_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_sel |=> $stable(ar_q[1]));

    assert_hold_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !bg_sel && (mode == 2'b00 || mode == 2'b11) |=> $stable(ar_q[0]));

    assert_no_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !load && !step && bg_sel |=> $stable(ar_q[1]));
endmodule

// File: rtl/segport_top.sv
module segport_top #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 64,
    parameter int DEPTH  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cyc_valid,
    input  logic                       cyc_write,
    input  logic                       mem_target,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(WORD_W/DATA_W)-1:0] seg_start,
    input  logic [$clog2(WORD_W/DATA_W)-1:0] seg_end,
    input  logic [1:0]                 step_mode,
    input  logic                       bg_sel,
    input  logic                       ar_load,
    input  logic [$clog2(DEPTH)-1:0]   ar_load_val,
    input  logic                       instr_step,
    output logic [DATA_W-1:0]          rd_data,
    output logic [WORD_W-1:0]          cmp_word,
    output logic [$clog2(DEPTH)-1:0]   addr_out
);
    localparam int NSEG  = WORD_W / DATA_W;
    localparam int SEL_W = $clog2(NSEG);
    localparam int AW    = $clog2(DEPTH);

    logic             wr_fire, rd_fire;
    logic [SEL_W-1:0] wr_pos, rd_pos;
    logic             wr_at_end, rd_at_end;
    logic [DATA_W-1:0] rd_seg;
    logic             end_hit, do_step;

    assign wr_fire = cyc_valid && cyc_write;
    assign rd_fire = cyc_valid && !cyc_write;

    segport_seg_ctr #(.NSEG(NSEG), .SEL_W(SEL_W)) u_wr_ctr (
        .clk(clk), .rst_n(rst_n), .adv(wr_fire),
        .lim_start(seg_start), .lim_end(seg_end),
        .pos(wr_pos), .at_end(wr_at_end)
    );

    segport_seg_ctr #(.NSEG(NSEG), .SEL_W(SEL_W)) u_rd_ctr (
        .clk(clk), .rst_n(rst_n), .adv(rd_fire),
        .lim_start(seg_start), .lim_end(seg_end),
        .pos(rd_pos), .at_end(rd_at_end)
    );

    segport_cmp_reg #(.DATA_W(DATA_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_fire && !mem_target),
        .wr_sel(wr_pos), .wdata(wr_data), .rd_sel(rd_pos),
        .word(cmp_word), .rd_seg(rd_seg)
    );

    assign rd_data = mem_target ? '0 : rd_seg;
    assign end_hit = cyc_valid && mem_target && (cyc_write ? wr_at_end : rd_at_end);
    assign do_step = instr_step || end_hit;

    segport_addr_unit #(.DEPTH(DEPTH), .AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(ar_load), .load_val(ar_load_val),
        .step(do_step), .mode(step_mode), .bg_sel(bg_sel), .addr(addr_out)
    );
endmodule

// File: tb/sim_segport_top.sv
module sim_segport_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0, cyc_write = 1'b0, mem_target = 1'b0;
    logic [15:0] wr_data = '0;
    logic [1:0]  seg_start = 2'd0, seg_end = 2'd3, step_mode = 2'b00;
    logic        bg_sel = 1'b0, ar_load = 1'b0, instr_step = 1'b0;
    logic [3:0]  ar_load_val = '0;
    logic [15:0] rd_data;
    logic [63:0] cmp_word;
    logic [3:0]  addr_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    segport_top u0 (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .mem_target(mem_target), .wr_data(wr_data), .seg_start(seg_start),
        .seg_end(seg_end), .step_mode(step_mode), .bg_sel(bg_sel),
        .ar_load(ar_load), .ar_load_val(ar_load_val), .instr_step(instr_step),
        .rd_data(rd_data), .cmp_word(cmp_word), .addr_out(addr_out)
    );

    // vector: bit16 = write, bits15:0 = write data or expected read data
    localparam logic [16:0] VEC [11] = '{
        {1'b1, 16'h1111}, {1'b1, 16'h2222}, {1'b1, 16'h3333}, {1'b1, 16'h4444},
        {1'b0, 16'h1111}, {1'b0, 16'h2222}, {1'b0, 16'h3333}, {1'b0, 16'h4444},
        {1'b1, 16'h5555}, {1'b0, 16'h5555}, {1'b0, 16'h2222}
    };

    task automatic tick();
        @(posedge clk);
        #1;
        cyc_valid = 1'b0; instr_step = 1'b0; ar_load = 1'b0;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    task automatic cyc(logic wr, logic [15:0] d);
        cyc_valid = 1'b1; cyc_write = wr; wr_data = d;
        tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #1;
        do_reset();
        chk("R1 comparand", cmp_word, 64'h0);
        chk("R1 addr", {60'h0, addr_out}, 64'h0);
        chk("R1 rd_data", {48'h0, rd_data}, 64'h0);

        // table walk: start 0, end 3
        for (int i = 0; i < 11; i++) begin
            if (!VEC[i][16])
                chk("R3 R5 table read", {48'h0, rd_data}, {48'h0, VEC[i][15:0]});
            cyc(VEC[i][16], VEC[i][15:0]);
        end
        chk("R2 R5 table word", cmp_word, 64'h4444_3333_2222_5555);

        // R4: limits 2..3
        do_reset();
        seg_start = 2'd2; seg_end = 2'd3;
        cyc(1'b1, 16'hAAAA); cyc(1'b1, 16'hBBBB); cyc(1'b1, 16'hCCCC);
        cyc(1'b1, 16'hDDDD); cyc(1'b1, 16'hEEEE);
        chk("R4 write wrap", cmp_word, 64'hDDDD_EEEE_BBBB_AAAA);
        cyc(1'b0, 16'h0); cyc(1'b0, 16'h0); cyc(1'b0, 16'h0);
        chk("R4 read seg3", {48'h0, rd_data}, 64'hDDDD);
        cyc(1'b0, 16'h0);
        chk("R4 read reload", {48'h0, rd_data}, 64'hEEEE);

        // address behaviour
        do_reset();
        seg_start = 2'd0; seg_end = 2'd3; step_mode = 2'b01;
        ar_load = 1'b1; ar_load_val = 4'd5; tick();
        chk("R9 load", {60'h0, addr_out}, 64'd5);
        mem_target = 1'b1;
        cyc(1'b1, 16'hFFFF); cyc(1'b1, 16'hFFFF); cyc(1'b1, 16'hFFFF);
        chk("R11 no step mid", {60'h0, addr_out}, 64'd5);
        cyc(1'b1, 16'hFFFF);
        chk("R7 end step up", {60'h0, addr_out}, 64'd6);
        chk("R6 comparand kept", cmp_word, 64'h0);
        chk("R3 mem rd zero", {48'h0, rd_data}, 64'h0);
        cyc(1'b0, 16'h0); cyc(1'b0, 16'h0); cyc(1'b0, 16'h0); cyc(1'b0, 16'h0);
        chk("R7 read end step", {60'h0, addr_out}, 64'd7);
        mem_target = 1'b0;
        step_mode = 2'b10; instr_step = 1'b1; tick();
        chk("R8 instr step down", {60'h0, addr_out}, 64'd6);
        step_mode = 2'b11; instr_step = 1'b1; tick();
        chk("R7 hold mode", {60'h0, addr_out}, 64'd6);
        ar_load = 1'b1; ar_load_val = 4'd0; tick();
        step_mode = 2'b10; instr_step = 1'b1; tick();
        chk("R7 wrap down", {60'h0, addr_out}, 64'd15);
        step_mode = 2'b01; instr_step = 1'b1; tick();
        chk("R7 wrap up", {60'h0, addr_out}, 64'd0);
        ar_load = 1'b1; ar_load_val = 4'd9; instr_step = 1'b1; tick();
        chk("R9 load over step", {60'h0, addr_out}, 64'd9);
        bg_sel = 1'b1; #1;
        chk("R10 bg reset", {60'h0, addr_out}, 64'd0);
        instr_step = 1'b1; tick();
        chk("R10 bg step", {60'h0, addr_out}, 64'd1);
        bg_sel = 1'b0; #1;
        chk("R10 fg kept", {60'h0, addr_out}, 64'd9);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule